// File: doc/BRIEF.md
# Five-Level Phase-Shifted PWM Modulator

This block drives one phase leg of a five-level flying-capacitor converter. A signed reference sample is compared against four triangular carriers that are spread a quarter of a carrier period apart. Each comparison commands one upper switch, and the matching lower switch gets the opposite level. Both switches of a pair stay off for a programmable gap after every change of command.

The reference is taken once per carrier period, at the valley of the first carrier, and held until the next valley. A strobe restarts all four carriers at their quarter offsets, loads a new half-period length and takes the reference at once. Alongside the gates the block reports the region the held reference lies in and the 4-bit command of the upper switches. A downstream balancing stage uses these two outputs.

Top module: `fcpwm_mod`

## Requirements
- R1: While reset is held, all eight gate outputs are low, the state word is 0000 and the region code is 01, since the held reference resets to zero.
- R2: The region code comes from the held reference r, a 16-bit two's-complement value in which 16384 means 0.5 per unit. It is 11 when r > 16384, 10 when 0 < r <= 16384, 01 when -16384 < r <= 0, and 00 when r <= -16384.
- R3: Carrier 1 counts 0,1,...,H,H-1,...,1 and then repeats, for a period of 2H clocks, where H is the held half-period. Upper switch 1 is commanded on exactly when c*65536 < (r+32768)*H, where c is the carrier value.
- R4: The reference is taken only on a strobe and on the clock edge where carrier 1 is at 0. A change of the reference input between those points leaves the region code and the switch commands unchanged.
- R5: Carrier k+1 leads carrier 1 by k*H/2 clocks (k = 1,2,3), so upper switch k+1 at time t equals the command of switch 1 at time t + k*H/2. H must be even and at least 4.
- R6: While the held reference is above 0.5 per unit, the state word only takes the values 1110, 1111, 0111, 1011 and 1101.
- R7: The high-side and low-side gates of one pair are never high together. After any change in a switch command, both gates of that pair stay low for DEAD clocks. After that gap, the gate on the commanded side goes high.
- R8: The state word holds the upper-switch commands, with switch 1 in bit 3 and switch 4 in bit 0. Gate bit 0 belongs to switch 1. A command changes one clock after the comparison that sets it.
- R9: A strobe loads the half-period input, presets carriers 1 to 4 to 0 rising, H/2 rising, H falling and H/2 falling, and takes the reference. The next period then runs at the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sync | input | 1 | Restart strobe: reload half-period, preset carriers, take reference |
| half_per | input | CW | Carrier half-period in clocks, even, at least 4 |
| ref_in | input | DW | Signed modulating reference, full scale = 1 per unit |
| gate_hi | output | 4 | Upper switch gates, bit 0 = switch 1 |
| gate_lo | output | 4 | Lower switch gates, complementary with dead time |
| region | output | 2 | Region code of the held reference |
| state | output | 4 | Upper switch commands, switch 1 in the MSB |

## Verification
The bench builds the block with a 16-bit reference, a 12-bit counter and a dead time of 5 clocks. That gap is long enough to see, yet shorter than most pulses. A reference near -1 per unit with H = 32 gives pulses of 3 clocks, shorter than the gap, so a restarted gap can be checked. The bench runs both H = 64 and H = 32, so a reload by strobe changes the period it observes. References just above and at 0.5 per unit place the region boundaries and the top-region state set within reach.

// File: rtl/fcpwm_mod.sv
`timescale 1ns/1ps
module fcpwm_mod #(
  parameter int DW       = 16,
  parameter int CW       = 12,
  parameter int DEAD     = 8,
  parameter int HALF_DEF = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync,
  input  logic [CW-1:0]        half_per,
  input  logic signed [DW-1:0] ref_in,
  output logic [3:0]           gate_hi,
  output logic [3:0]           gate_lo,
  output logic [1:0]           region,
  output logic [3:0]           state
);
  localparam int PW = DW + CW;
  localparam int TW = (DEAD > 0) ? $clog2(DEAD + 1) : 1;
  localparam logic signed [DW-1:0] HALF_PU = DW'(1) << (DW - 2);
  localparam logic [PW-1:0] PROD_RST = PW'(HALF_DEF) << (DW - 1);

  logic [CW-1:0]        hper;
  logic signed [DW-1:0] ref_q;
  logic [PW-1:0]        prod;
  logic                 valley;

  wire [CW-1:0] h_src   = sync ? half_per : hper;
  wire [DW-1:0] off_bin = {~ref_in[DW-1], ref_in[DW-2:0]};

  // R3 R5 R9: four carriers, R7: dead time per pair
  for (genvar k = 0; k < 4; k++) begin : ch
    logic [CW-1:0] cnt;
    logic          up;
    logic          cmd;
    logic [TW-1:0] tmr;

    wire [CW-1:0] pre_rst = (k == 0) ? '0 : (k == 2) ? CW'(HALF_DEF) : CW'(HALF_DEF / 2);
    wire [CW-1:0] pre_syn = (k == 0) ? '0 : (k == 2) ? half_per : (half_per >> 1);
    wire          raw     = {cnt, {DW{1'b0}}} < prod;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= pre_rst;
        up  <= (k < 2);
      end else if (sync) begin
        cnt <= pre_syn;
        up  <= (k < 2);
      end else if (up) begin
        cnt <= cnt + 1'b1;
        if (cnt + 1'b1 == hper) up <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) up <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd <= 1'b0;
        tmr <= TW'(DEAD);
      end else if (raw != cmd) begin
        cmd <= raw;
        tmr <= TW'(DEAD);
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end
    end

    assign gate_hi[k]  = cmd & (tmr == '0);
    assign gate_lo[k]  = ~cmd & (tmr == '0);
    assign state[3-k]  = cmd;
  end

  assign valley = (ch[0].cnt == '0);

  // R4: reference held from valley to valley
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hper  <= CW'(HALF_DEF);
      ref_q <= '0;
      prod  <= PROD_RST;
    end else if (sync || valley) begin
      hper  <= h_src;
      ref_q <= ref_in;
      prod  <= PW'(off_bin) * PW'(h_src);
    end
  end

  // R2
  assign region = (ref_q > HALF_PU)  ? 2'b11 :
                  (ref_q > 0)        ? 2'b10 :
                  (ref_q > -HALF_PU) ? 2'b01 : 2'b00;
endmodule

module fcpwm_mod_chk #(parameter int DEAD = 8) (
  input logic       clk,
  input logic       rst_n,
  input logic       sync,
  input logic       valley,
  input logic [3:0] gate_hi,
  input logic [3:0] gate_lo,
  input logic [1:0] region,
  input logic [3:0] state
);
  wire [3:0] g_any = {gate_hi[0] | gate_lo[0], gate_hi[1] | gate_lo[1],
                      gate_hi[2] | gate_lo[2], gate_hi[3] | gate_lo[3]};

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == 4'b0000);

  a_r6_top_states: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 2'b11 && $past(region) == 2'b11) |->
      (state inside {4'b1110, 4'b1111, 4'b0111, 4'b1011, 4'b1101}));

  a_r4_region_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !valley) |=> $stable(region));

  if (DEAD > 0) begin : g_gap
    a_r7_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(state) |-> ((g_any & (state ^ $past(state))) == 4'b0000));
  end
endmodule

bind fcpwm_mod fcpwm_mod_chk #(.DEAD(DEAD)) chk_i (
  .clk(clk), .rst_n(rst_n), .sync(sync), .valley(valley),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .region(region), .state(state)
);

// File: tb/fcpwm_mod_tb.sv
`timescale 1ns/1ps
module fcpwm_mod_tb_top;
  localparam int DT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic [11:0] half_per = 12'd64;
  logic signed [15:0] ref_in = '0;
  logic [3:0]  gate_hi, gate_lo, state;
  logic [1:0]  region;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fcpwm_mod #(.DW(16), .CW(12), .DEAD(DT), .HALF_DEF(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync(sync), .half_per(half_per), .ref_in(ref_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .region(region), .state(state));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int tri_f(input int n, input int h);
    int m = n % (2 * h);
    return (m <= h) ? m : 2 * h - m;
  endfunction

  function automatic bit on_f(input int r, input int h, input int c);
    longint u = longint'(r) + 32768;
    return (longint'(c) * 65536) < u * longint'(h);
  endfunction

  task automatic do_sync(input int r, input int h);
    @(negedge clk);
    ref_in = 16'(r);
    half_per = 12'(h);
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(gate_hi == 4'b0 && gate_lo == 4'b0, "R1", "gates in reset", {gate_hi, gate_lo}, 0);
    check(state == 4'b0, "R1", "state in reset", state, 0);
    check(region == 2'b01, "R1", "region in reset", region, 1);
  endtask

  task automatic t_region(input int r, input int exp);
    do_sync(r, 64);
    check(region == 2'(exp), "R2", $sformatf("region ref=%0d", r), region, exp);
  endtask

  // R3 R5 R6 R7 R8 R9
  task automatic t_pattern(input int r, input int h, input bit top);
    int mis[4];
    int gmis = 0;
    int topbad = 0;
    int age[4];
    bit known[4];
    logic [3:0] prev;
    do_sync(r, h);
    prev = state;
    for (int k = 0; k < 4; k++) begin mis[k] = 0; age[k] = 0; known[k] = 1'b0; end
    for (int i = 1; i <= 4 * h; i++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        bit s = state[3-k];
        if (s != on_f(r, h, tri_f(i - 1 + k * h / 2, h))) mis[k]++;
        if (s != prev[3-k]) begin age[k] = 0; known[k] = 1'b1; end
        else age[k]++;
        if (gate_hi[k] && gate_lo[k]) gmis++;
        if (known[k]) begin
          if (gate_hi[k] != (s && age[k] >= DT)) gmis++;
          if (gate_lo[k] != (!s && age[k] >= DT)) gmis++;
        end
      end
      if (top && !(state inside {4'b1110, 4'b1111, 4'b0111, 4'b1011, 4'b1101})) topbad++;
      prev = state;
    end
    check(mis[0] == 0, "R3", $sformatf("switch1 cmd ref=%0d H=%0d mismatches", r, h), mis[0], 0);
    check(mis[1] + mis[2] + mis[3] == 0, "R5",
          $sformatf("offset switches ref=%0d H=%0d mismatches", r, h), mis[1] + mis[2] + mis[3], 0);
    check(gmis == 0, "R7", $sformatf("dead time ref=%0d H=%0d mismatches", r, h), gmis, 0);
    if (top) check(topbad == 0, "R6", $sformatf("top states ref=%0d", r), topbad, 0);
  endtask

  task automatic t_hold();
    int held_bad = 0;
    do_sync(-20000, 64);
    @(negedge clk);
    ref_in = 16'(20000);
    for (int i = 2; i <= 128; i++) begin
      @(negedge clk);
      if (region != 2'b00) held_bad++;
    end
    check(held_bad == 0, "R4", "region held mid-period", held_bad, 0);
    @(negedge clk);
    check(region == 2'b11, "R4", "region after valley", region, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_region(32767, 3);
    t_region(16385, 3);
    t_region(16384, 2);
    t_region(1, 2);
    t_region(0, 1);
    t_region(-16383, 1);
    t_region(-16384, 0);
    t_region(-32768, 0);
    t_pattern(0, 64, 1'b0);
    t_pattern(20000, 64, 1'b1);
    t_pattern(-20000, 64, 1'b0);
    t_pattern(16385, 64, 1'b1);
    t_pattern(30000, 64, 1'b1);
    t_pattern(-30000, 32, 1'b0);
    t_pattern(10000, 32, 1'b0);
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule